// File: doc/BRIEF.md
# Fast A20 gate command decoder

This block listens to the stream of host writes aimed at a keyboard-controller-style command/data port. It drives the gate-A20 output entirely in hardware, with no interrupt and no firmware step. Each write carries a byte, a channel number and a flag that marks it as a command (1) or as data (0). When the host sends the command byte 0xD1 on the gate channel, the block arms itself. The next data byte on that channel then sets the gate output to the value of its bit 1.

An enable input selects between this hardware path and an idle state. While the enable is low, the gate is held at logic 1 and nothing is armed. The gate level is also presented on a status output that mirrors the pin.

The write stream uses a valid/ready handshake. The block never applies back-pressure: `wr_ready` is always 1. A write is therefore taken in every cycle where `wr_valid` is 1. Writes that are not for the gate channel are accepted too, and then ignored.

Top module: `fast_a20_gate`

## Requirements
- R1: While `en` is 0, on every clock edge the gate is driven to 1 and the armed state is cleared. Writes accepted in such a cycle have no effect on either.
- R2: A synchronous active-high `rst` forces the gate to 1 on the next edge and clears the armed state.
- R3: An accepted command write (`wr_is_cmd`=1) of 0xD1 on channel 0 with `en`=1 arms the block. The next accepted data write (`wr_is_cmd`=0) on channel 0 then loads bit 1 of its byte into the gate on the following clock edge: 0x02 gives 1, 0x00 gives 0, 0xFD gives 0, 0xFF gives 1. That data write also disarms the block.
- R4: An accepted data write on channel 0 while the block is not armed leaves the gate unchanged.
- R5: An accepted command write on channel 0 with any value other than 0xD1 disarms the block and leaves the gate unchanged.
- R6: Writes on any channel other than 0 (channels 1 to 3) never change the gate or the armed state.
- R7: `wr_ready` is always 1. A cycle with `wr_valid`=0 changes nothing, whatever the other write inputs hold.
- R8: `gate_status` equals `gate_o` in every cycle.
- R9: If `en` is 0 in the same cycle as a data write that would otherwise load the gate, the gate becomes 1.
- R10: After `en` rises, the gate stays at 1 until the first qualifying data write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Hardware gate path enable |
| wr_valid | input | 1 | Host write present |
| wr_ready | output | 1 | Always 1; the block accepts every write |
| wr_chan | input | 2 | Host channel number of the write |
| wr_is_cmd | input | 1 | 1 = command write, 0 = data write |
| wr_byte | input | 8 | Written byte |
| gate_o | output | 1 | Gate-A20 output level |
| gate_status | output | 1 | Readback of the gate level |

## Verification
Two events can land in the same cycle: `en` falling, and a data write that would load the gate while the block is armed. The bench forces this collision on purpose. It arms the block with 0xD1, then drops `en` in the exact cycle of a data byte whose bit 1 is 0, and expects the gate to read 1 afterwards. It also expects a later data byte to have no effect until 0xD1 is sent again. The same collision also occurs by chance in the random phase, where a bench-side reference model judges every cycle.

// File: rtl/a20_pkg.sv
package a20_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef enum logic {ST_IDLE = 1'b0, ST_ARMED = 1'b1} trk_state_t;
  localparam byte_t GATE_CMD = 8'hD1;
endpackage

// File: rtl/a20_host_filter.sv
module a20_host_filter #(
  parameter int unsigned CHAN_W    = 2,
  parameter int unsigned GATE_CHAN = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wr_valid,
  input  logic [CHAN_W-1:0] wr_chan,
  output logic              wr_ready,
  output logic              hit
);
  localparam logic [CHAN_W-1:0] MY_CHAN = CHAN_W'(GATE_CHAN);

  assign wr_ready = 1'b1;
  assign hit      = wr_valid && wr_ready && (wr_chan == MY_CHAN);

  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    hit |-> (wr_valid && en !== 1'bx)); // R7
endmodule

// File: rtl/a20_cmd_tracker.sv
module a20_cmd_tracker
  import a20_pkg::*;
#(
  parameter int unsigned SEL_BIT = 1
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  logic  hit,
  input  logic  is_cmd,
  input  byte_t wbyte,
  output logic  load,
  output logic  load_val
);
  trk_state_t st_q, st_d;

  assign load     = en && hit && !is_cmd && (st_q == ST_ARMED);
  assign load_val = wbyte[SEL_BIT];

  always_comb begin
    st_d = st_q;
    if (!en) begin
      st_d = ST_IDLE;
    end else if (hit) begin
      if (is_cmd) st_d = (wbyte == GATE_CMD) ? ST_ARMED : ST_IDLE;
      else        st_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  AST_DIS_DISARMS: assert property (@(posedge clk) disable iff (rst)
    !en |=> (st_q == ST_IDLE)); // R1
  AST_OTHER_CMD_DISARMS: assert property (@(posedge clk) disable iff (rst)
    (en && hit && is_cmd && wbyte != GATE_CMD) |=> (st_q == ST_IDLE)); // R5
  AST_D1_ARMS: assert property (@(posedge clk) disable iff (rst)
    (en && hit && is_cmd && wbyte == GATE_CMD) |=> (st_q == ST_ARMED)); // R3
  AST_NOHIT_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (en && !hit) |=> $stable(st_q)); // R6
endmodule

// File: rtl/a20_gate_reg.sv
module a20_gate_reg (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic load,
  input  logic load_val,
  output logic gate
);
  always_ff @(posedge clk) begin
    if (rst)       gate <= 1'b1;
    else if (!en)  gate <= 1'b1;
    else if (load) gate <= load_val;
  end

  AST_DIS_HOLDS_ONE: assert property (@(posedge clk) disable iff (rst)
    !en |=> gate); // R1
  AST_LOAD_TAKES_BIT: assert property (@(posedge clk) disable iff (rst)
    (en && load) |=> (gate == $past(load_val))); // R3
  AST_NO_LOAD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (en && !load) |=> $stable(gate)); // R4
endmodule

// File: rtl/fast_a20_gate.sv
module fast_a20_gate
  import a20_pkg::*;
#(
  parameter int unsigned CHAN_W    = 2,
  parameter int unsigned GATE_CHAN = 0,
  parameter int unsigned SEL_BIT   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [CHAN_W-1:0] wr_chan,
  input  logic              wr_is_cmd,
  input  logic [7:0]        wr_byte,
  output logic              gate_o,
  output logic              gate_status
);
  logic hit, load, load_val, gate;

  a20_host_filter #(.CHAN_W(CHAN_W), .GATE_CHAN(GATE_CHAN)) u_filter (
    .clk(clk), .rst(rst), .en(en), .wr_valid(wr_valid), .wr_chan(wr_chan),
    .wr_ready(wr_ready), .hit(hit));

  a20_cmd_tracker #(.SEL_BIT(SEL_BIT)) u_track (
    .clk(clk), .rst(rst), .en(en), .hit(hit), .is_cmd(wr_is_cmd),
    .wbyte(wr_byte), .load(load), .load_val(load_val));

  a20_gate_reg u_gate (
    .clk(clk), .rst(rst), .en(en), .load(load), .load_val(load_val),
    .gate(gate));

  assign gate_o      = gate;
  assign gate_status = gate;

  AST_RST_GATE_ONE: assert property (@(posedge clk)
    rst |=> gate_o); // R2
endmodule

// File: tb/test_fast_a20_gate.sv
module test_fast_a20_gate;
  logic       clk = 1'b0;
  logic       rst, en, wr_valid, wr_is_cmd;
  logic [1:0] wr_chan;
  logic [7:0] wr_byte;
  logic       wr_ready, gate_o, gate_status;

  int total = 0;
  int bad   = 0;
  bit m_gate, m_arm;

  always #2 clk = ~clk;

  fast_a20_gate i_fast_a20_gate (
    .clk(clk), .rst(rst), .en(en), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_chan(wr_chan), .wr_is_cmd(wr_is_cmd), .wr_byte(wr_byte),
    .gate_o(gate_o), .gate_status(gate_status));

  function automatic bit [1:0] ref_next(bit g, bit a, bit r, bit e, bit v,
                                        bit [1:0] ch, bit c, bit [7:0] b);
    bit ng = g, na = a;
    if (r || !e) begin ng = 1'b1; na = 1'b0; end
    else if (v && ch == 2'd0) begin
      if (c) na = (b == 8'hD1);
      else begin
        if (a) ng = b[1];
        na = 1'b0;
      end
    end
    return {ng, na};
  endfunction

  task automatic chk(string tag, bit act, bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(bit r, bit e, bit v, bit [1:0] ch, bit c, bit [7:0] b,
                     string tag);
    bit [1:0] n;
    @(negedge clk);
    rst = r; en = e; wr_valid = v; wr_chan = ch; wr_is_cmd = c; wr_byte = b;
    n = ref_next(m_gate, m_arm, r, e, v, ch, c, b);
    @(posedge clk);
    m_gate = n[1]; m_arm = n[0];
    #1;
    chk(tag, gate_o, m_gate);
    chk("R8", gate_status, gate_o);
    chk("R7", wr_ready, 1'b1);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed = 32'd1234;
    void'($urandom(seed));
    rst = 1; en = 0; wr_valid = 0; wr_chan = 0; wr_is_cmd = 0; wr_byte = 0;
    m_gate = 1; m_arm = 0;
    cyc(1, 0, 0, 0, 0, 8'h00, "R2");
    chk("R2", gate_o, 1'b1);
    cyc(0, 0, 1, 0, 1, 8'hD1, "R1");
    cyc(0, 0, 1, 0, 0, 8'h00, "R1");
    cyc(0, 1, 0, 0, 0, 8'h00, "R10");
    chk("R10", gate_o, 1'b1);
    cyc(0, 1, 1, 0, 1, 8'hD1, "R3");
    cyc(0, 1, 1, 0, 0, 8'h00, "R3");
    chk("R3", gate_o, 1'b0);
    cyc(0, 1, 1, 0, 0, 8'h02, "R4");
    chk("R4", gate_o, 1'b0);
    cyc(0, 1, 1, 0, 1, 8'hD1, "R3");
    cyc(0, 1, 1, 0, 0, 8'hFF, "R3");
    chk("R3", gate_o, 1'b1);
    cyc(0, 1, 1, 0, 1, 8'hD1, "R3");
    cyc(0, 1, 1, 0, 0, 8'hFD, "R3");
    chk("R3", gate_o, 1'b0);
    cyc(0, 1, 1, 0, 1, 8'hD1, "R3");
    cyc(0, 1, 1, 0, 0, 8'h02, "R3");
    chk("R3", gate_o, 1'b1);
    cyc(0, 1, 1, 0, 1, 8'hD1, "R5");
    cyc(0, 1, 1, 0, 1, 8'hAA, "R5");
    cyc(0, 1, 1, 0, 0, 8'h00, "R5");
    chk("R5", gate_o, 1'b1);
    cyc(0, 1, 1, 2'd1, 1, 8'hD1, "R6");
    cyc(0, 1, 1, 0, 0, 8'h00, "R6");
    chk("R6", gate_o, 1'b1);
    cyc(0, 1, 1, 0, 1, 8'hD1, "R6");
    cyc(0, 1, 1, 2'd3, 0, 8'h00, "R6");
    chk("R6", gate_o, 1'b1);
    cyc(0, 1, 0, 0, 0, 8'h00, "R7");
    chk("R7", gate_o, 1'b1);
    cyc(0, 1, 1, 0, 0, 8'h00, "R6");
    chk("R6", gate_o, 1'b0);
    cyc(0, 1, 1, 0, 1, 8'hD1, "R9");
    cyc(0, 1, 1, 0, 0, 8'h02, "R9");
    cyc(0, 1, 1, 0, 1, 8'hD1, "R9");
    cyc(0, 0, 1, 0, 0, 8'h00, "R9");
    chk("R9", gate_o, 1'b1);
    cyc(0, 1, 1, 0, 0, 8'h00, "R9");
    chk("R9", gate_o, 1'b1);
    cyc(0, 1, 1, 0, 1, 8'hD1, "R2");
    cyc(1, 1, 0, 0, 0, 8'h00, "R2");
    cyc(0, 1, 1, 0, 0, 8'h00, "R2");
    chk("R2", gate_o, 1'b1);
    for (int i = 0; i < 3000; i++) begin
      bit [7:0] b = 8'($urandom);
      bit c = ($urandom % 3) == 0;
      if (c && ($urandom % 2) == 0) b = 8'hD1;
      cyc(($urandom % 200) == 0, ($urandom % 12) != 0, ($urandom % 4) != 0,
          2'(($urandom % 3 == 0) ? $urandom : 0), c, b, "R3");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule